// File: doc/BRIEF.md
# Serial Flash Read-Command Target

This block plays the device side of a serial flash memory for one command: the single-bit read. It watches the four SPI pins, which it samples in its own system clock domain. These are an active-low select, the serial clock, serial data in, and serial data out with a separate output enable for the pad buffer. When a transaction starts, the block takes in an 8-bit opcode and then an address of 24 or 32 bits. It then streams bytes from a synchronous byte-wide memory, starting at that address and stepping up one byte at a time. After the last location of the array it continues from location zero.

Input bits are sampled on rising serial-clock edges and output bits change after falling edges, in SPI mode 0. The memory sits outside the block and is reached through a one-byte read port. The block fetches the next byte while the current one is shifting, so the bit stream never stalls. A `busy_i` input marks an erase, program or write cycle in progress. A read whose opcode completes while it is high is refused and leaves the memory port untouched. The `addr4_i` input chooses between 24-bit and 32-bit addressing.

Top module: `spi_rd_target`

## Requirements
- R1: After reset, and while `spi_cs_n` is high, `spi_so_oe` is 0 and `mem_rd_en` is 0.
- R2: The opcode is 8 bits, most significant bit first, sampled on rising `spi_sck`. Only 8'h03 starts a read. Any other value keeps `spi_so_oe` at 0 and `mem_rd_en` at 0 until select is released.
- R3: With `addr4_i` = 0, the opcode is followed by 24 address bits, most significant bit first, sampled on rising `spi_sck`.
- R4: With `addr4_i` = 1 at the end of the opcode, the address phase is 32 bits long.
- R5: `spi_so_oe` stays 0 through the opcode and address phases. It becomes 1 after the falling `spi_sck` edge that follows the last address bit.
- R6: Data leaves on `spi_so` most significant bit first. A new bit is presented after each falling `spi_sck` edge, and the first byte is the one at the received address.
- R7: Each later byte comes from the previous address plus one.
- R8: Only the low AW address bits are used. After location 2^AW-1 the stream continues at location 0 and never stops.
- R9: Raising `spi_cs_n` at any bit, including mid-byte during data output, ends the transaction. `spi_so_oe` returns to 0, and the next transaction starts fresh.
- R10: If `busy_i` is 1 when the opcode completes, the read is refused: no `mem_rd_en` pulse is issued and `spi_so_oe` stays 0 for the rest of that selection.
- R11: `mem_rd_en` is a one-cycle pulse with `mem_addr` valid, and `mem_rdata` is expected in the following cycle. A read with N whole bytes clocked out issues exactly N+2 pulses: one at the end of the address, and one prefetch at each byte start, including the prefetch at the falling edge after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low chip select pin |
| spi_sck | input | 1 | Serial clock pin |
| spi_si | input | 1 | Serial data into the target |
| spi_so | output | 1 | Serial data out of the target |
| spi_so_oe | output | 1 | Output enable for the `spi_so` pad; 0 means high impedance |
| busy_i | input | 1 | Erase, program or write cycle in progress |
| addr4_i | input | 1 | 1 selects 32-bit addressing |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the strobe |

## Verification
The read path is driven with several start addresses. A low address with four bytes shows ordering and increment. Addresses just below the top of the array, given once with clean upper bits and once with junk in the bits above AW, separate correct wraparound from truncation errors. A 32-bit address is used with the mode input set, and an all-ones 32-bit address combines the long address phase with the wrap. An unknown opcode and a read issued while busy must both leave the output undriven and the memory port silent. A read cut off three bits into its second byte, followed by a fresh read, shows that deselecting clears every counter.

// File: rtl/spi_rd_pkg.sv
`timescale 1ns/1ps
package spi_rd_pkg;

  localparam logic [7:0] OPC_READ = 8'h03;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_ADR,
    PH_DAT,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic si_pin,
  output logic cs_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] cs_r;
  logic [MSB:0] sck_r;
  logic [MSB:0] si_r;
  logic         sck_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_r  <= 1'b1;
          sck_r <= 1'b0;
          si_r  <= 1'b0;
        end else begin
          cs_r  <= cs_n_pin;
          sck_r <= sck_pin;
          si_r  <= si_pin;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          cs_r  <= '1;
          sck_r <= '0;
          si_r  <= '0;
        end else begin
          cs_r  <= {cs_r[MSB-1:0], cs_n_pin};
          sck_r <= {sck_r[MSB-1:0], sck_pin};
          si_r  <= {si_r[MSB-1:0], si_pin};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_r[MSB];
  end

  assign cs_s     = cs_r[MSB];
  assign si_s     = si_r[MSB];
  assign sck_rise = sck_r[MSB] & ~sck_q;
  assign sck_fall = ~sck_r[MSB] & sck_q;

endmodule

// File: rtl/spi_rd_ctrl.sv
`timescale 1ns/1ps
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si_s,
  input  logic          busy_i,
  input  logic          addr4_i,
  output logic          byte_load,
  output logic          rej_pulse,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr
);

  localparam int SHW = 31;

  phase_t          phase;
  logic [5:0]      cnt;
  logic [SHW-1:0]  sh;
  logic            wide;
  logic [2:0]      bitcnt;
  logic [5:0]      adr_last;
  logic [7:0]      opc_now;

  assign adr_last  = wide ? 6'd31 : 6'd23;
  assign opc_now   = {sh[6:0], si_s};
  assign byte_load = (phase == PH_DAT) && sck_fall && (bitcnt == 3'd0) && !cs_s;

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      phase     <= PH_OPC;
      cnt       <= '0;
      sh        <= '0;
      wide      <= 1'b0;
      bitcnt    <= '0;
      rej_pulse <= 1'b0;
      mem_rd_en <= 1'b0;
      if (rst) mem_addr <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      rej_pulse <= 1'b0;
      unique case (phase)
        PH_OPC: begin
          if (sck_rise) begin
            sh  <= {sh[SHW-2:0], si_s};
            cnt <= cnt + 6'd1;
            if (cnt == 6'd7) begin
              cnt <= '0;
              if (opc_now == OPC_READ && !busy_i) begin
                phase <= PH_ADR;
                wide  <= addr4_i;
              end else begin
                phase     <= PH_SKIP;
                rej_pulse <= 1'b1;
              end
            end
          end
        end
        PH_ADR: begin
          if (sck_rise) begin
            sh  <= {sh[SHW-2:0], si_s};
            cnt <= cnt + 6'd1;
            if (cnt == adr_last) begin
              mem_addr  <= {sh[AW-2:0], si_s};
              mem_rd_en <= 1'b1;
              bitcnt    <= '0;
              phase     <= PH_DAT;
            end
          end
        end
        PH_DAT: begin
          if (sck_fall) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd0) begin
              mem_addr  <= mem_addr + 1'b1;
              mem_rd_en <= 1'b1;
            end
          end
        end
        PH_SKIP: begin
          phase <= PH_SKIP;
        end
        default: phase <= PH_SKIP;
      endcase
    end
  end

endmodule

// File: rtl/spi_rd_shift.sv
`timescale 1ns/1ps
module spi_rd_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_s,
  input  logic       sck_fall,
  input  logic       byte_load,
  input  logic       mem_rd_en,
  input  logic [7:0] mem_rdata,
  output logic       spi_so,
  output logic       spi_so_oe
);

  logic [7:0] nxt_byte;
  logic [6:0] sh;
  logic       rd_q;

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      nxt_byte  <= '0;
      sh        <= '0;
      rd_q      <= 1'b0;
      spi_so    <= 1'b0;
      spi_so_oe <= 1'b0;
    end else begin
      rd_q <= mem_rd_en;
      if (rd_q) nxt_byte <= mem_rdata;
      if (byte_load) begin
        spi_so_oe <= 1'b1;
        spi_so    <= nxt_byte[7];
        sh        <= nxt_byte[6:0];
      end else if (sck_fall && spi_so_oe) begin
        spi_so <= sh[6];
        sh     <= {sh[5:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_rd_target.sv
`timescale 1ns/1ps
module spi_rd_target #(
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_si,
  output logic          spi_so,
  output logic          spi_so_oe,
  input  logic          busy_i,
  input  logic          addr4_i,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);

  logic cs_s;
  logic sck_rise;
  logic sck_fall;
  logic si_s;
  logic byte_load;
  logic rej_pulse;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n_pin (spi_cs_n),
    .sck_pin  (spi_sck),
    .si_pin   (spi_si),
    .cs_s     (cs_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s)
  );

  spi_rd_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (cs_s),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .si_s      (si_s),
    .busy_i    (busy_i),
    .addr4_i   (addr4_i),
    .byte_load (byte_load),
    .rej_pulse (rej_pulse),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr)
  );

  spi_rd_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (cs_s),
    .sck_fall  (sck_fall),
    .byte_load (byte_load),
    .mem_rd_en (mem_rd_en),
    .mem_rdata (mem_rdata),
    .spi_so    (spi_so),
    .spi_so_oe (spi_so_oe)
  );

endmodule

// File: rtl/spi_rd_target_chk.sv
`timescale 1ns/1ps
module spi_rd_target_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          so_oe,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          rej
);

  logic          seen;
  logic [AW-1:0] last;
  logic          rej_flag;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      seen     <= 1'b0;
      last     <= '0;
      rej_flag <= 1'b0;
    end else begin
      if (rd_en) begin
        seen <= 1'b1;
        last <= rd_addr;
      end
      if (rej) rej_flag <= 1'b1;
    end
  end

  AST_NO_READ_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !rd_en); // R1
  AST_UNDRIVEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !so_oe); // R9
  AST_DRIVE_STARTS_WITH_FETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> rd_en); // R5
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (seen && rd_en && !cs_n) |-> (rd_addr == AW'(last + 1'b1))); // R7
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (seen && rd_en && !cs_n && (last == {AW{1'b1}})) |-> (rd_addr == '0)); // R8
  AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rej_flag && !cs_n) |-> (!rd_en && !so_oe)); // R10

endmodule

bind spi_rd_target spi_rd_target_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (spi_cs_n),
  .so_oe   (spi_so_oe),
  .rd_en   (mem_rd_en),
  .rd_addr (mem_addr),
  .rej     (rej_pulse)
);

// File: tb/tb_spi_rd_target.sv
`timescale 1ns/1ps
module tb_spi_rd_target;

  localparam int AW   = 10;
  localparam int HALF = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_cs_n = 1'b1;
  logic          spi_sck = 1'b0;
  logic          spi_si = 1'b0;
  logic          spi_so;
  logic          spi_so_oe;
  logic          busy_i = 1'b0;
  logic          addr4_i = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  bit oe_early;

  always #2 clk = ~clk;

  spi_rd_target #(.AW(AW)) dut (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_si    (spi_si),
    .spi_so    (spi_so),
    .spi_so_oe (spi_so_oe),
    .busy_i    (busy_i),
    .addr4_i   (addr4_i),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return 8'((32'(a) * 29) ^ (32'(a) >> 3) ^ 32'h5A);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_f(mem_addr);
    if (!rst && mem_rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic v);
    spi_si = v;
    wait_clk(HALF);
    if (spi_so_oe) oe_early = 1'b1;
    spi_sck = 1'b1;
    wait_clk(HALF);
    spi_sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] op, input logic [31:0] adr, input bit four,
                      input int nbytes, input int tail, input bit want, input string tag);
    logic [7:0]    got;
    logic [AW-1:0] ea;
    int            nb;
    int            base;
    base     = rd_cnt;
    oe_early = 1'b0;
    addr4_i  = four;
    nb       = four ? 32 : 24;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) put_bit(op[i]);
    for (int i = nb - 1; i >= 0; i--) put_bit(adr[i]);
    chk(!oe_early, {"R5 output enabled early ", tag}, 32'(oe_early), 0);
    for (int b = 0; b < nbytes; b++) begin
      got = '0;
      for (int i = 7; i >= 0; i--) begin
        wait_clk(HALF);
        got[i] = spi_so;
        if (i == 7) chk(spi_so_oe == want, {"R5 output enable ", tag}, 32'(spi_so_oe), 32'(want));
        spi_sck = 1'b1;
        wait_clk(HALF);
        spi_sck = 1'b0;
      end
      if (want) begin
        ea = adr[AW-1:0] + AW'(b);
        chk(got == mem_f(ea), {"R6 data byte ", tag}, 32'(got), 32'(mem_f(ea)));
      end
    end
    for (int t = 0; t < tail; t++) begin
      wait_clk(HALF);
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(8);
    chk(spi_so_oe == 1'b0, {"R9 released after deselect ", tag}, 32'(spi_so_oe), 0);
    if (tail == 0)
      chk(rd_cnt - base == (want ? nbytes + 2 : 0), {"R11 read strobes ", tag},
          32'(rd_cnt - base), 32'(want ? nbytes + 2 : 0));
    wait_clk(HALF);
  endtask

  task automatic t_reset;
    chk(spi_so_oe == 1'b0, "R1 enable after reset", 32'(spi_so_oe), 0);
    chk(mem_rd_en == 1'b0, "R1 strobe after reset", 32'(mem_rd_en), 0);
  endtask

  task automatic t_basic;
    xfer(8'h03, 32'h0000_0010, 1'b0, 4, 0, 1'b1, "R2 R3 R7 basic");
  endtask

  task automatic t_wrap;
    xfer(8'h03, 32'h0000_03FE, 1'b0, 4, 0, 1'b1, "R8 wrap");
    xfer(8'h03, 32'h00AB_03FD, 1'b0, 5, 0, 1'b1, "R8 upper bits");
  endtask

  task automatic t_four;
    xfer(8'h03, 32'h1234_5005, 1'b1, 3, 0, 1'b1, "R4 long address");
    xfer(8'h03, 32'hFFFF_FFFF, 1'b1, 2, 0, 1'b1, "R4 R8 long wrap");
  endtask

  task automatic t_badop;
    xfer(8'h0B, 32'h0000_0040, 1'b0, 2, 0, 1'b0, "R2 other opcode");
  endtask

  task automatic t_busy;
    busy_i = 1'b1;
    xfer(8'h03, 32'h0000_0020, 1'b0, 2, 0, 1'b0, "R10 busy");
    busy_i = 1'b0;
  endtask

  task automatic t_abort;
    xfer(8'h03, 32'h0000_0100, 1'b0, 1, 3, 1'b1, "R9 mid-byte abort");
    xfer(8'h03, 32'h0000_0200, 1'b0, 2, 0, 1'b1, "R9 after abort");
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_basic();
    t_wrap();
    t_four();
    t_badop();
    t_busy();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule